// File: doc/BRIEF.md
# PCI host configuration address translator

This block is the configuration address register of a PCI host bridge. Software selects a target device by writing a word in which one bit of the upper field (bits 31 down to 11) acts as the device select line. The block finds the lowest such bit and keeps a normalized configuration address. That stored form carries an enable flag, bus zero, an encoded device number, the function and the register offset. When software reads the register back, the block rebuilds the one-hot select form from the stored device number.

The same block folds the interrupt pins of a row of device slots onto four shared host interrupt lines. The line is chosen by rotating the pin number by the slot's device number. The four lines sit at a fixed offset inside a wider host interrupt vector. A build parameter adds a byte-reversal stage on both the write and the read path, for a processor that uses big-endian byte order.

Read handling is a two-state machine. `ST_IDLE` waits for an access. A read strobe moves it to `ST_RESP` (transition `GO_RESP`), in which the response word is presented for one cycle. From `ST_RESP` it returns to `ST_IDLE` (`GO_IDLE`), or stays in `ST_RESP` when a new read strobe arrives (`STAY_RESP`). In `ST_IDLE` with no read strobe the machine holds (`HOLD_IDLE`). Writes are taken in any state.

Top module: `pci_cfgaddr_xlate`

## Requirements
- R1: After reset the stored address is zero. A read then returns 32'h0000_0001, which is device 0 in one-hot form with function 0 and offset 0, and `cfg_self_sel` is low.
- R2: A write stores the index of the lowest set bit among bits 31..11 of the word as the device number in stored bits 15:11. It sets enable bit 31, keeps bus bits 23:16 at zero, copies word bits 10:2 unchanged and clears bits 1:0.
- R3: A write with none of bits 31..11 set stores device number 0, because the scan result of 32 is truncated to five bits.
- R4: A read returns a word with a single bit set at the stored device number. Bits 10:8 hold the stored function and bits 7:2 hold the stored offset, ORed together. Bit 31 is not returned.
- R5: When a write and a read are strobed in the same cycle, the read returns the value held before that write, and the write takes effect.
- R6: `cpu_addr` and `cpu_size` have no effect: every offset and every access width acts as a full-word access to the one register.
- R7: With `BIG_ENDIAN_CPU` set, the four bytes of the write data are reversed before translation, and the four bytes of the read result are reversed before they are returned.
- R8: Pin p of slot k has device number FIRST_DEV+k, with pins A..D numbered 0..3 and bit index 4*k+p of `dev_irq`. It drives host line ((p + FIRST_DEV + k) mod 4). Each line is the OR of all inputs routed to it and appears on `host_irq[IRQ_BASE + line]`.
- R9: Bits of `host_irq` outside IRQ_BASE..IRQ_BASE+3 are always zero.
- R10: `cfg_self_sel` is high exactly when the stored address is enabled, names bus 0 and names device 11 function 0, the host bridge's own slot.
- R11: `cpu_rvalid` is high for exactly the one cycle after each cycle in which `cpu_rd` is high, and `cpu_rdata` is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Write strobe for the address register |
| cpu_rd | input | 1 | Read strobe for the address register |
| cpu_addr | input | ADDR_W | Byte offset within the register window (ignored) |
| cpu_size | input | 2 | Access width code (ignored) |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read response in one-hot select form |
| cpu_rvalid | output | 1 | Read response valid |
| dev_irq | input | 4*NUM_DEV | Slot interrupt pins, bit 4*k+p is pin p of slot k |
| host_irq | output | HOST_IRQ_W | Host interrupt vector with the four shared lines at IRQ_BASE |
| cfg_self_sel | output | 1 | Stored address targets the host bridge's own device |

## Verification
The read and write paths can be strobed in the same cycle. This is the case where an ordering error would stay hidden. The bench raises `cpu_wr` and `cpu_rd` together with a write word whose device differs from the one stored. It expects the response to show the old device, and it expects a following read to show the new one. Interrupt routing runs alongside register accesses, and the bench checks it after each change of `dev_irq` against a rotation computed in the bench.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rd_state_t;

    localparam int SCAN_LO      = 11;
    localparam int DEV_LSB      = 11;
    localparam int DEV_W        = 5;
    localparam logic [7:0] BRIDGE_DEVFN = 8'(11 << 3);

    function automatic logic [31:0] swap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/cfg_addr_encoder.sv
module cfg_addr_encoder
    import pcfg_pkg::*;
(
    input  logic [31:0] wr_word,
    output logic [31:0] stored
);
    logic [5:0] hit_idx;

    // lowest set bit in 31..SCAN_LO wins; none set leaves 32
    always_comb begin
        hit_idx = 6'd32;
        for (int i = 31; i >= SCAN_LO; i--) begin
            if (wr_word[i]) hit_idx = 6'(i);
        end
    end

    always_comb begin
        stored = (wr_word & 32'h0000_07FC);
        stored[31] = 1'b1;
        stored[DEV_LSB +: DEV_W] = hit_idx[DEV_W-1:0];
    end
endmodule

// File: rtl/cfg_addr_decoder.sv
module cfg_addr_decoder
    import pcfg_pkg::*;
(
    input  logic [31:0] stored,
    output logic [31:0] rd_word
);
    logic [7:0] devfn;
    logic       unused_bits;

    assign devfn       = stored[15:8];
    assign unused_bits = ^{stored[31:16], stored[1:0]};

    always_comb begin
        rd_word = 32'd1 << devfn[7:3];
        rd_word = rd_word | {21'd0, devfn[2:0], 8'd0} | {24'd0, stored[7:2], 2'b00};
    end
endmodule

// File: rtl/irq_router.sv
module irq_router #(
    parameter int NUM_DEV   = 4,
    parameter int FIRST_DEV = 12
) (
    input  logic [4*NUM_DEV-1:0] dev_irq,
    output logic [3:0]           shared_irq
);
    localparam int NPIN = 4;

    for (genvar l = 0; l < 4; l++) begin : g_line
        always_comb begin
            shared_irq[l] = 1'b0;
            for (int k = 0; k < NUM_DEV; k++) begin
                for (int p = 0; p < NPIN; p++) begin
                    if (((p + FIRST_DEV + k) % 4) == l)
                        shared_irq[l] = shared_irq[l] | dev_irq[NPIN*k + p];
                end
            end
        end
    end
endmodule

// File: rtl/pci_cfgaddr_xlate.sv
module pci_cfgaddr_xlate
    import pcfg_pkg::*;
#(
    parameter int ADDR_W         = 12,
    parameter int NUM_DEV        = 4,
    parameter int FIRST_DEV      = 12,
    parameter int HOST_IRQ_W     = 12,
    parameter int IRQ_BASE       = 8,
    parameter bit BIG_ENDIAN_CPU = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_wr,
    input  logic                  cpu_rd,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [1:0]            cpu_size,
    input  logic [31:0]           cpu_wdata,
    output logic [31:0]           cpu_rdata,
    output logic                  cpu_rvalid,
    input  logic [4*NUM_DEV-1:0]  dev_irq,
    output logic [HOST_IRQ_W-1:0] host_irq,
    output logic                  cfg_self_sel
);
    localparam int IRQ_TOP = IRQ_BASE + 3;

    rd_state_t   state_q, state_d;
    logic [31:0] addr_q;
    logic [31:0] wr_in, enc_out, dec_out, rd_out;
    logic [3:0]  shared_irq;
    logic        unused_ok;

    assign unused_ok = ^{cpu_addr, cpu_size};

    // optional byte reversal on both directions
    if (BIG_ENDIAN_CPU) begin : g_swap
        assign wr_in  = swap32(cpu_wdata);
        assign rd_out = swap32(dec_out);
    end else begin : g_noswap
        assign wr_in  = cpu_wdata;
        assign rd_out = dec_out;
    end

    cfg_addr_encoder u_enc (.wr_word(wr_in), .stored(enc_out));
    cfg_addr_decoder u_dec (.stored(addr_q), .rd_word(dec_out));

    irq_router #(.NUM_DEV(NUM_DEV), .FIRST_DEV(FIRST_DEV)) u_irq (
        .dev_irq    (dev_irq),
        .shared_irq (shared_irq)
    );

    always_comb begin
        host_irq = '0;
        host_irq[IRQ_BASE +: 4] = shared_irq;
    end

    // address register: written in any state
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= 32'd0;
        else if (cpu_wr) addr_q <= enc_out;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: GO_RESP, STAY_RESP, GO_IDLE, HOLD_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = cpu_rd ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = cpu_rd ? ST_RESP : ST_IDLE;
        endcase
    end

    // outputs: response word captured from the pre-write register value
    always_ff @(posedge clk) begin
        if (!rst_n)      cpu_rdata <= 32'd0;
        else if (cpu_rd) cpu_rdata <= rd_out;
    end

    always_comb begin
        cpu_rvalid = 1'b0;
        unique case (state_q)
            ST_IDLE: cpu_rvalid = 1'b0;
            ST_RESP: cpu_rvalid = 1'b1;
        endcase
    end

    assign cfg_self_sel = addr_q[31] && (addr_q[23:16] == 8'd0) && (addr_q[15:8] == BRIDGE_DEVFN);

    AST_WR_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |=> addr_q[31] && addr_q[1:0] == 2'b00 && addr_q[23:16] == 8'd0); // R2
    AST_HOLD_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> $stable(addr_q)); // R2
    AST_RD_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd |=> cpu_rvalid); // R11
    AST_NO_SPUR_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |=> !cpu_rvalid); // R11
    AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |=> $stable(cpu_rdata)); // R5
    AST_SELF_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_self_sel |-> addr_q[31]); // R10

    always_comb begin
        if (rst_n) begin
            AST_IRQ_OUTSIDE_ZERO: assert ((host_irq & ~(HOST_IRQ_W'(4'hF) << IRQ_BASE)) == '0); // R9
        end
    end

    initial begin
        AST_IRQ_FITS: assert (IRQ_TOP < HOST_IRQ_W); // R9
    end
endmodule

// File: tb/sim_pci_cfgaddr_xlate.sv
module sim_pci_cfgaddr_xlate;
    localparam int NUM_DEV   = 4;
    localparam int FIRST_DEV = 12;
    localparam int HW        = 12;
    localparam int BASE      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [11:0] cpu_addr = '0;
    logic [1:0]  cpu_size = 2'd2;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic        rvalid0, rvalid1, self0, self1;
    logic [4*NUM_DEV-1:0] dev_irq = '0;
    logic [HW-1:0] hirq0, hirq1;

    int vectors = 0;
    int fails   = 0;
    logic [31:0] model0, model1;

    always #2 clk = ~clk;

    pci_cfgaddr_xlate #(.BIG_ENDIAN_CPU(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
        .cpu_rdata(rdata0), .cpu_rvalid(rvalid0), .dev_irq(dev_irq),
        .host_irq(hirq0), .cfg_self_sel(self0));

    pci_cfgaddr_xlate #(.BIG_ENDIAN_CPU(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
        .cpu_rdata(rdata1), .cpu_rvalid(rvalid1), .dev_irq(dev_irq),
        .host_irq(hirq1), .cfg_self_sel(self1));

    function automatic logic [31:0] bswap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] exp_store(input logic [31:0] w);
        int idx = 32;
        for (int i = 11; i < 32; i++) if (w[i] && idx == 32) idx = i;
        return 32'h8000_0000 | (w & 32'h7FC) | (32'(idx % 32) << 11);
    endfunction

    function automatic logic [31:0] exp_read(input logic [31:0] r);
        int d = int'(r[15:11]);
        return (32'd1 << d) | (32'(r[10:8]) << 8) | (r & 32'hFC);
    endfunction

    function automatic logic exp_self(input logic [31:0] r);
        return r[31] && r[23:16] == 0 && r[15:11] == 5'd11 && r[10:8] == 0;
    endfunction

    function automatic logic [HW-1:0] exp_irq(input logic [4*NUM_DEV-1:0] v);
        logic [HW-1:0] o = '0;
        for (int k = 0; k < NUM_DEV; k++)
            for (int p = 0; p < 4; p++)
                if (v[4*k+p]) o[BASE + ((p + FIRST_DEV + k) % 4)] = 1'b1;
        return o;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] w);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_wdata = w;
        @(negedge clk);
        cpu_wr = 1'b0;
        model0 = exp_store(w);
        model1 = exp_store(bswap(w));
    endtask

    task automatic check_read(input string req);
        @(negedge clk);
        cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        chk(req, rdata0, exp_read(model0));
        chk({req, " R7 swapped"}, rdata1, bswap(exp_read(model1)));
        chk("R11 rvalid", {31'd0, rvalid0}, 32'd1);
        chk({req, " R10 self"}, {31'd0, self0}, {31'd0, exp_self(model0)});
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] old0, old1, w;
        void'($urandom(32'd20240611));
        model0 = 32'd0; model1 = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 self low", {31'd0, self0}, 32'd0);
        check_read("R1 reset read");
        chk("R1 raw read", rdata0, 32'h0000_0001);
        chk("R1 raw swapped", rdata1, 32'h0100_0000);
        @(negedge clk);
        chk("R11 rvalid one cycle", {31'd0, rvalid0}, 32'd0);
        chk("R9 irq idle", 32'(hirq0), 32'd0);

        // R2 / R10: host bridge slot
        do_write(32'h0000_0800);
        check_read("R2 dev11");
        chk("R10 self high", {31'd0, self0}, 32'd1);
        do_write(32'h0000_0900);
        check_read("R10 func1 not self");
        do_write(32'hFFFF_FFFF);
        check_read("R2 all ones");
        do_write(32'h8000_07FF);
        check_read("R2 bit31 dev");
        // R3 no select bit
        do_write(32'h0000_07FF);
        check_read("R3 no select");
        chk("R3 raw", rdata0, 32'h0000_07FD);
        do_write(32'h0000_0000);
        check_read("R3 zero word");

        // R5 simultaneous write and read
        do_write(32'h0001_0344);
        old0 = model0; old1 = model1;
        @(negedge clk);
        cpu_wr = 1'b1; cpu_rd = 1'b1; cpu_wdata = 32'h0400_0128;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b0;
        chk("R5 old value", rdata0, exp_read(old0));
        chk("R5 old swapped", rdata1, bswap(exp_read(old1)));
        model0 = exp_store(32'h0400_0128);
        model1 = exp_store(bswap(32'h0400_0128));
        check_read("R5 new value");

        // R6 random writes with random offsets and widths
        for (int n = 0; n < 150; n++) begin
            w = $urandom();
            if (n % 5 == 0) w = w & 32'h0000_0FFF;
            cpu_addr = 12'($urandom());
            cpu_size = 2'($urandom());
            do_write(w);
            cpu_addr = 12'($urandom());
            cpu_size = 2'($urandom());
            check_read("R6 R4 random");
        end

        // R8 / R9 interrupt routing
        for (int k = 0; k < NUM_DEV; k++)
            for (int p = 0; p < 4; p++) begin
                @(negedge clk);
                dev_irq = '0; dev_irq[4*k+p] = 1'b1;
                #1;
                chk("R8 single pin", 32'(hirq0), 32'(exp_irq(dev_irq)));
            end
        for (int n = 0; n < 100; n++) begin
            @(negedge clk);
            dev_irq = 16'($urandom());
            #1;
            chk("R8 R9 random irq", 32'(hirq0), 32'(exp_irq(dev_irq)));
            chk("R8 swap inst irq", 32'(hirq1), 32'(exp_irq(dev_irq)));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule